// File: doc/BRIEF.md
# Bit Elastic Store with Stuff Request

This block is a single-bit elastic buffer placed between a tributary write clock and a faster local read clock. Each incoming bit goes into a small ring of cells on the write clock. The local side reads one bit in every read slot that a common controller offers. The read clock is nominally faster than the write clock, so the store slowly drains. It is topped up by stuffing: on some read slots the read side dwells on its current cell and consumes no bit.

Fill level is measured with a phase flag keyed to one reference cell (cell 0). A write into that cell sets the flag and a read of it clears the flag. The read side counts how many read-clock cycles the flag is high over a fixed window. When that count falls below a programmable threshold, the block raises a stuff request. The controller answers with a grant at a stuffing opportunity of its own choosing, and the read pointer holds for that slot. Two sticky flags report spills, one for each direction of pointer collision. Pointers cross between the clock domains as Gray codes through two-flop synchronizers.

Top module: `elastic_stuff_store`

## Requirements
- R1: After rst_ni is released, rd_bit_o, rd_stuff_o, stuff_req_o, spill_wr_o and spill_rd_o are all 0.
- R2: The k-th bit written after reset goes into cell k mod 4. A read slot (rd_en_i=1, stuff_grant_i=0) puts the bit at the read pointer on rd_bit_o at that rclk_i edge and advances the pointer, so bits come out in the order they were written.
- R3: The store holds up to 3 unread bits without setting either spill flag.
- R4: The phase flag is high from a write into cell 0 until the read of cell 0. The read side counts the rclk_i cycles in which the synchronized flag is high over each 64-cycle window, so the count runs from 0 (flag never high) to 64 (flag always high).
- R5: At the end of each window, stuff_req_o is set if the count is strictly less than thresh_i (7 bits). A count of 64 raises no request with a threshold of 64, but does raise one with a threshold of 65.
- R6: Once set, stuff_req_o stays high until stuff_grant_i is seen, even if later windows would not request.
- R7: A read slot with stuff_grant_i=1 is a dwell. rd_bit_o shows the current cell, rd_stuff_o goes to 1 and the pointer does not advance, so the next normal read returns the same bit.
- R8: stuff_grant_i clears stuff_req_o at that edge, and clearing takes priority over setting. The request is re-evaluated at the next window end.
- R9: A read slot issued while the read pointer equals the synchronized write pointer (store empty) sets the sticky spill_rd_o.
- R10: A write whose next write pointer equals the synchronized read pointer sets the sticky spill_wr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Tributary write clock |
| rclk_i | input | 1 | Local read clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write strobe for wr_bit_i |
| wr_bit_i | input | 1 | Incoming data bit |
| rd_en_i | input | 1 | Read slot strobe |
| stuff_grant_i | input | 1 | Grant pulse; turns this read slot into a dwell |
| thresh_i | input | 7 | Low-occupancy threshold for the flag-high count |
| rd_bit_o | output | 1 | Bit delivered in the last read slot |
| rd_stuff_o | output | 1 | Last read slot was a dwell |
| stuff_req_o | output | 1 | Stuff request to the common controller |
| spill_wr_o | output | 1 | Sticky write-side collision flag (wclk_i domain) |
| spill_rd_o | output | 1 | Sticky read-side collision flag (rclk_i domain) |

## Verification
Data order is tried with a table of bit patterns of length one to three. Between them these patterns carry the pointers around the ring several times, so a wrong cell index or a wrong wrap shows up as a swapped bit. Occupancy is measured in two extreme states. In one, the reference cell holds an unread bit, giving a full count that sits on the 64/65 threshold edge. In the other the store is empty, giving a zero count. Together these separate a wrong comparison from a wrong count. Dwell, request hold, clearing and re-raising are driven with grants both inside and outside read slots. Finally, over-writing and over-reading separate the two sticky spill flags.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int unsigned GW = 8;

  function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/es_sync.sv
module es_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/es_wr_port.sv
module es_wr_port #(
  parameter int DEPTH    = 4,
  parameter int REF_CELL = 0,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  input  logic [PTR_W-1:0] rptr_gray_i,
  output logic [DEPTH-1:0] cells_o,
  output logic [PTR_W-1:0] wptr_gray_o,
  output logic             ref_tog_o,
  output logic             spill_o
);
  localparam logic [PTR_W-1:0] REF_IDX = PTR_W'(REF_CELL);

  logic [PTR_W-1:0] wptr_q, wptr_nxt, rptr_bin;
  logic [DEPTH-1:0] cells_q;

  assign wptr_nxt = wptr_q + PTR_W'(1);
  assign rptr_bin = PTR_W'(es_pkg::gray2bin(es_pkg::GW'(rptr_gray_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q      <= '0;
      wptr_gray_o <= '0;
      cells_q     <= '0;
      ref_tog_o   <= 1'b0;
      spill_o     <= 1'b0;
    end else if (wr_en_i) begin
      cells_q[wptr_q] <= wr_bit_i;
      wptr_q          <= wptr_nxt;
      wptr_gray_o     <= PTR_W'(es_pkg::bin2gray(es_pkg::GW'(wptr_nxt)));
      if (wptr_q == REF_IDX) ref_tog_o <= ~ref_tog_o;
      // writing would land on the cell the reader has not yet left
      if (wptr_nxt == rptr_bin) spill_o <= 1'b1;
    end
  end

  assign cells_o = cells_q;
endmodule

// File: rtl/es_rd_port.sv
module es_rd_port #(
  parameter int DEPTH    = 4,
  parameter int REF_CELL = 0,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             hold_i,
  input  logic [DEPTH-1:0] cells_i,
  input  logic [PTR_W-1:0] wptr_gray_i,
  output logic             rd_bit_o,
  output logic             rd_stuff_o,
  output logic [PTR_W-1:0] rptr_gray_o,
  output logic             ref_tog_o,
  output logic             spill_o
);
  localparam logic [PTR_W-1:0] REF_IDX = PTR_W'(REF_CELL);

  logic [PTR_W-1:0] rptr_q, rptr_nxt, wptr_bin;

  assign rptr_nxt = rptr_q + PTR_W'(1);
  assign wptr_bin = PTR_W'(es_pkg::gray2bin(es_pkg::GW'(wptr_gray_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q      <= '0;
      rptr_gray_o <= '0;
      rd_bit_o    <= 1'b0;
      rd_stuff_o  <= 1'b0;
      ref_tog_o   <= 1'b0;
      spill_o     <= 1'b0;
    end else begin
      rd_stuff_o <= rd_en_i & hold_i;
      if (rd_en_i) begin
        rd_bit_o <= cells_i[rptr_q];
        if (!hold_i) begin
          rptr_q      <= rptr_nxt;
          rptr_gray_o <= PTR_W'(es_pkg::bin2gray(es_pkg::GW'(rptr_nxt)));
          if (rptr_q == REF_IDX) ref_tog_o <= ~ref_tog_o;
          if (rptr_q == wptr_bin) spill_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/es_stuff_ctl.sv
module es_stuff_ctl #(
  parameter int WIN_LEN = 64,
  localparam int WIN_W  = $clog2(WIN_LEN),
  localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             w_tog_i,
  input  logic             r_tog_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             grant_i,
  output logic             req_o
);
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] hi_q, total;
  logic             flag, win_end;

  // set by a write into the reference cell, cleared by its read
  assign flag    = w_tog_i ^ r_tog_i;
  assign total   = hi_q + CNT_W'(flag);
  assign win_end = (win_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      hi_q  <= '0;
      req_o <= 1'b0;
    end else begin
      if (win_end) begin
        win_q <= '0;
        hi_q  <= '0;
      end else begin
        win_q <= win_q + WIN_W'(1);
        hi_q  <= total;
      end
      if (grant_i) req_o <= 1'b0;
      else if (win_end && (total < thresh_i)) req_o <= 1'b1;
    end
  end
endmodule

// File: rtl/elastic_stuff_store.sv
module elastic_stuff_store #(
  parameter int DEPTH    = 4,
  parameter int WIN_LEN  = 64,
  parameter int REF_CELL = 0,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_bit_i,
  input  logic             rd_en_i,
  input  logic             stuff_grant_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             rd_bit_o,
  output logic             rd_stuff_o,
  output logic             stuff_req_o,
  output logic             spill_wr_o,
  output logic             spill_rd_o
);
  logic [DEPTH-1:0] cells;
  logic [PTR_W-1:0] wptr_gray, wptr_gray_s, rptr_gray, rptr_gray_s;
  logic             w_tog, w_tog_s, r_tog;

  es_wr_port #(.DEPTH(DEPTH), .REF_CELL(REF_CELL)) i_wr (
    .clk_i(wclk_i), .rst_ni, .wr_en_i, .wr_bit_i,
    .rptr_gray_i(rptr_gray_s), .cells_o(cells), .wptr_gray_o(wptr_gray),
    .ref_tog_o(w_tog), .spill_o(spill_wr_o)
  );

  es_sync #(.W(PTR_W)) i_sync_wptr (
    .clk_i(rclk_i), .rst_ni, .d_i(wptr_gray), .q_o(wptr_gray_s)
  );
  es_sync #(.W(1)) i_sync_wtog (
    .clk_i(rclk_i), .rst_ni, .d_i(w_tog), .q_o(w_tog_s)
  );
  es_sync #(.W(PTR_W)) i_sync_rptr (
    .clk_i(wclk_i), .rst_ni, .d_i(rptr_gray), .q_o(rptr_gray_s)
  );

  es_rd_port #(.DEPTH(DEPTH), .REF_CELL(REF_CELL)) i_rd (
    .clk_i(rclk_i), .rst_ni, .rd_en_i, .hold_i(stuff_grant_i),
    .cells_i(cells), .wptr_gray_i(wptr_gray_s), .rd_bit_o, .rd_stuff_o,
    .rptr_gray_o(rptr_gray), .ref_tog_o(r_tog), .spill_o(spill_rd_o)
  );

  es_stuff_ctl #(.WIN_LEN(WIN_LEN)) i_ctl (
    .clk_i(rclk_i), .rst_ni, .w_tog_i(w_tog_s), .r_tog_i(r_tog),
    .thresh_i, .grant_i(stuff_grant_i), .req_o(stuff_req_o)
  );
endmodule

// File: rtl/es_store_chk.sv
module es_store_chk #(
  parameter int PTR_W = 2
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic             stuff_grant_i,
  input logic             stuff_req_o,
  input logic             rd_stuff_o,
  input logic             spill_wr_o,
  input logic             spill_rd_o,
  input logic [PTR_W-1:0] rptr_gray
);
  AST_REQ_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    stuff_req_o && !stuff_grant_i |=> stuff_req_o); // R6
  AST_GRANT_CLEARS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    stuff_grant_i |=> !stuff_req_o); // R8
  AST_DWELL_HOLDS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_en_i && stuff_grant_i |=> $stable(rptr_gray) && rd_stuff_o); // R7
  AST_READ_ADVANCES: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_en_i && !stuff_grant_i |=> !$stable(rptr_gray) && !rd_stuff_o); // R2
  AST_SPILL_RD_STICKY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    spill_rd_o |=> spill_rd_o); // R9
  AST_SPILL_WR_STICKY: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    spill_wr_o |=> spill_wr_o); // R10
endmodule

bind elastic_stuff_store es_store_chk #(.PTR_W(PTR_W)) i_chk (
  .wclk_i, .rclk_i, .rst_ni, .rd_en_i, .stuff_grant_i, .stuff_req_o,
  .rd_stuff_o, .spill_wr_o, .spill_rd_o, .rptr_gray
);

// File: tb/test_elastic_stuff_store.sv
`timescale 1ns/1ps
module test_elastic_stuff_store;
  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, wr_bit = 0, rd_en = 0, grant = 0;
  logic [6:0] thresh = '0;
  logic rd_bit, rd_stuff, req, spill_wr, spill_rd;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 rclk = ~rclk;     // 125 MHz local read clock
  always #5.5 wclk = ~wclk;   // slower tributary clock

  elastic_stuff_store i_elastic_stuff_store (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_bit_i(wr_bit), .rd_en_i(rd_en), .stuff_grant_i(grant),
    .thresh_i(thresh), .rd_bit_o(rd_bit), .rd_stuff_o(rd_stuff),
    .stuff_req_o(req), .spill_wr_o(spill_wr), .spill_rd_o(spill_rd)
  );

  // {length, bits written LSB first}
  localparam logic [4:0] VEC [6] = '{
    {2'd3, 3'b101}, {2'd3, 3'b010}, {2'd2, 3'b011},
    {2'd1, 3'b001}, {2'd3, 3'b110}, {2'd3, 3'b111}
  };

  task automatic check(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic write_bit(input logic b);
    @(negedge wclk); wr_en = 1; wr_bit = b;
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic read_slot(input logic g);
    @(negedge rclk); rd_en = 1; grant = g;
    @(negedge rclk); rd_en = 0; grant = 0;
  endtask

  task automatic grant_only();
    @(negedge rclk); grant = 1;
    @(negedge rclk); grant = 0;
  endtask

  task automatic rwait(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic wwait(input int n);
    repeat (n) @(negedge wclk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rwait(3);
    rst_n = 1;
    rwait(2);
    check("R1 rd_bit", rd_bit, 0);
    check("R1 rd_stuff", rd_stuff, 0);
    check("R1 stuff_req", req, 0);
    check("R1 spill_wr", spill_wr, 0);
    check("R1 spill_rd", spill_rd, 0);

    // unread bit in cell 0: flag high every cycle, count 64
    write_bit(1);
    rwait(150);
    thresh = 7'd64;
    rwait(150);
    check("R4 R5 count 64 vs thresh 64", req, 0);
    thresh = 7'd65;
    rwait(150);
    check("R5 count 64 vs thresh 65", req, 1);
    thresh = 7'd0;
    rwait(150);
    check("R6 request held", req, 1);
    grant_only();
    check("R8 grant clears", req, 0);
    read_slot(0);
    check("R2 first bit", rd_bit, 1);
    check("R2 not a dwell", rd_stuff, 0);
    wwait(6);

    // table walk over bit patterns
    foreach (VEC[v]) begin
      for (int i = 0; i < int'(VEC[v][4:3]); i++) write_bit(VEC[v][i]);
      rwait(6);
      for (int i = 0; i < int'(VEC[v][4:3]); i++) begin
        read_slot(0);
        check($sformatf("R2 vec%0d bit%0d", v, i), rd_bit, VEC[v][i]);
      end
      wwait(6);
    end
    check("R3 no write spill", spill_wr, 0);
    check("R3 no read spill", spill_rd, 0);

    // empty store: count 0
    thresh = 7'd1;
    rwait(150);
    check("R4 R5 empty store requests", req, 1);
    write_bit(1);
    write_bit(0);
    rwait(6);
    thresh = 7'd0;
    read_slot(1);
    check("R7 dwell bit", rd_bit, 1);
    check("R7 dwell flag", rd_stuff, 1);
    check("R8 cleared by grant", req, 0);
    read_slot(0);
    check("R7 same bit after dwell", rd_bit, 1);
    check("R7 flag drops", rd_stuff, 0);
    read_slot(0);
    check("R2 bit after dwell", rd_bit, 0);
    thresh = 7'd1;
    rwait(150);
    check("R8 re-evaluated", req, 1);
    grant_only();
    thresh = 7'd0;
    wwait(6);

    // spills
    write_bit(1); write_bit(1); write_bit(1);
    check("R3 three bits fit", spill_wr, 0);
    write_bit(0);
    check("R10 write collision", spill_wr, 1);
    rwait(6);
    check("R9 before over-read", spill_rd, 0);
    read_slot(0);
    check("R9 read collision", spill_rd, 1);
    wwait(10);
    check("R10 sticky", spill_wr, 1);
    rwait(10);
    check("R9 sticky", spill_rd, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule